// File: doc/BRIEF.md
# Iterative Seed-Hash Random Generator

This block produces 256-bit pseudorandom values from a 1024-bit seed that it holds on chip. A single 64-bit bidirectional port carries data both ways. While the block reports `ready`, each clock that has no generate request takes the port value as one seed beat. A rolling beat pointer places these beats into a 32-word by 32-bit register array. A generate request starts a run. The run makes 256 mixing passes over the stored words, and each pass modifies one word in place.

The passes flow through a two-stage pipeline, and each stage lasts five clocks. Stage one adds two neighbouring words. Stage two rotates that sum, folds it into a running accumulator, and writes back the accumulator plus the pass index. The three additions use three separate 32-bit adders. When the last pass retires, `done` rises and the block drives the first 64-bit result word onto the port. Each read pulse moves to the next word. After the fourth pulse the port is released and the block returns to loading.

Top module: `seedHashRng`

## Requirements
- R1: A synchronous active-high reset leaves `ready` high and `done` low, and the port is not driven. Seed memory contents are undefined after reset.
- R2: Each clock edge with `ready` high and `genReq` low stores the port value as one seed beat at the beat pointer p. Bits 31:0 go to word 2p and bits 63:32 go to word 2p+1. The pointer is 0 whenever `ready` becomes high, advances by one per beat, and wraps from 15 to 0.
- R3: A clock edge with `ready` high and `genReq` high starts a run, and `ready` is low in the next cycle. The port value in that cycle is not stored.
- R4: A run sets the accumulator to zero. Then, for pass p = 0..255 in order, it computes s = w[p mod 32] + w[(p+1) mod 32], adds s rotated left by 7 bits into the accumulator, and writes the accumulator plus p into w[p mod 32]. All arithmetic is modulo 2^32.
- R5: `done` goes high exactly 1285 clock edges after the starting edge: 257 pipeline steps of 5 clocks each.
- R6: While `done` is high the block drives result word r onto the port, where bits 31:0 are w[2r] and bits 63:32 are w[2r+1]. r starts at 0 and each edge with `readReq` high advances it by one.
- R7: The edge carrying the fourth read pulse clears `done` and sets `ready`.
- R8: `genReq` has no effect while a run is in progress or while `done` is high.
- R9: `readReq` has no effect while `done` is low, so read-out always starts at word 0.
- R10: A reset during a run abandons it: `ready` is high and `done` is low after the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| genReq | input | 1 | Start a run when sampled with ready high |
| readReq | input | 1 | Advance to the next result word while done |
| dataIo | inout | 64 | Seed beats in while ready, result words out while done |
| ready | output | 1 | Block is accepting seed beats and a start request |
| done | output | 1 | Result available on dataIo |

## Verification
Two pairs of events can share a clock edge. A generate request can coincide with a would-be seed beat, so the bench loads only 15 beats and raises `genReq` together with a distinctive value on the port in the sixteenth cycle. The reference model then keeps the previous contents of the last slot, and any stored beat shows up as a wrong result word. A generate request can also arrive during a run or while the result is held. Both are injected, and the bench judges them by the unchanged completion cycle, by `done` staying high, and by word 0 still appearing first. Read pulses issued while loading and while running must likewise leave read-out starting at word 0.

// File: rtl/rngPkg.sv
package rngPkg;
  localparam int DATA_W       = 64;
  localparam int WORD_W       = 32;
  localparam int DEPTH        = 32;
  localparam int PASSES       = 256;
  localparam int RESULT_BEATS = 4;

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int WPB    = DATA_W / WORD_W;
  localparam int BEATS  = DEPTH / WPB;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int PASS_W = $clog2(PASSES + 1);
  localparam int RD_W   = (RESULT_BEATS > 1) ? $clog2(RESULT_BEATS) : 1;

  typedef struct packed {
    logic              loadEn;
    logic [BEAT_W-1:0] loadBeat;
    logic              clearAcc;
    logic              issueEn;
    logic [PASS_W-1:0] issueIdx;
    logic              retireEn;
    logic [RD_W-1:0]   rdWord;
  } ctrlStrobes_t;
endpackage

// File: rtl/rngCtrl.sv
module rngCtrl
  import rngPkg::*;
#(
  parameter int STAGE_CYCLES = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         genReq,
  input  logic         readReq,
  output logic         ready,
  output logic         done,
  output ctrlStrobes_t strobes
);
  localparam int PH_W = $clog2(STAGE_CYCLES + 1);

  typedef enum logic [1:0] {ST_LOAD, ST_RUN, ST_DONE} rngState_t;

  rngState_t         state;
  logic [BEAT_W-1:0] loadPtr;
  logic [PH_W-1:0]   phase;
  logic [PASS_W-1:0] passCnt;
  logic [RD_W-1:0]   rdPtr;
  logic              tick;
  logic              lastTick;
  logic              lastRead;

  assign tick     = (state == ST_RUN) && (phase == PH_W'(STAGE_CYCLES - 1));
  assign lastTick = tick && (passCnt == PASS_W'(PASSES));
  assign lastRead = (state == ST_DONE) && readReq && (rdPtr == RD_W'(RESULT_BEATS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_LOAD;
      loadPtr <= '0;
      phase   <= '0;
      passCnt <= '0;
      rdPtr   <= '0;
    end else begin
      case (state)
        ST_LOAD: begin
          if (genReq) begin
            state   <= ST_RUN;
            phase   <= '0;
            passCnt <= '0;
          end else begin
            loadPtr <= loadPtr + 1'b1;
          end
        end
        ST_RUN: begin
          if (tick) begin
            phase   <= '0;
            passCnt <= passCnt + 1'b1;
            if (lastTick) begin
              state <= ST_DONE;
              rdPtr <= '0;
            end
          end else begin
            phase <= phase + 1'b1;
          end
        end
        ST_DONE: begin
          if (lastRead) begin
            state   <= ST_LOAD;
            loadPtr <= '0;
          end else if (readReq) begin
            rdPtr <= rdPtr + 1'b1;
          end
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  assign ready = (state == ST_LOAD);
  assign done  = (state == ST_DONE);

  always_comb begin
    strobes          = '0;
    strobes.loadEn   = ready && !genReq;
    strobes.loadBeat = loadPtr;
    strobes.clearAcc = ready && genReq;
    strobes.issueEn  = tick && (passCnt < PASS_W'(PASSES));
    strobes.issueIdx = passCnt;
    strobes.retireEn = tick && (passCnt != '0);
    strobes.rdWord   = rdPtr;
  end

  AST_READY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ready && done)); // R1
  AST_LOAD_PTR_START: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> loadPtr == '0); // R2
  AST_GEN_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    (ready && genReq) |=> (!ready && !done)); // R3
  AST_DONE_ON_STEP: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(phase) == PH_W'(STAGE_CYCLES - 1)); // R5
  AST_GEN_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!ready && genReq) |=> !ready); // R8
  AST_LAST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (done && readReq && rdPtr == RD_W'(RESULT_BEATS - 1)) |=> (ready && !done)); // R7
  AST_READ_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && !readReq) |=> (done && $stable(rdPtr))); // R6
endmodule

// File: rtl/rngDatapath.sv
module rngDatapath
  import rngPkg::*;
#(
  parameter int ROT_AMT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] loadData,
  output logic [DATA_W-1:0] rdData
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] s1Sum;
  logic [PASS_W-1:0] s1Idx;
  logic [ADDR_W-1:0] aAddr;
  logic [ADDR_W-1:0] bAddr;
  logic [WORD_W-1:0] sumAB;
  logic [WORD_W-1:0] rotSum;
  logic [WORD_W-1:0] accNext;
  logic [WORD_W-1:0] wbVal;

  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] x);
    return (x << ROT_AMT) | (x >> (WORD_W - ROT_AMT));
  endfunction

  assign aAddr = strobes.issueIdx[ADDR_W-1:0];
  assign bAddr = aAddr + 1'b1;

  // three adders of one pass
  assign sumAB   = mem[aAddr] + mem[bAddr];
  assign rotSum  = rotl(s1Sum);
  assign accNext = acc + rotSum;
  assign wbVal   = accNext + WORD_W'(s1Idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      s1Sum <= '0;
      s1Idx <= '0;
    end else begin
      if (strobes.clearAcc) begin
        acc <= '0;
      end else if (strobes.retireEn) begin
        acc <= accNext;
      end
      if (strobes.issueEn) begin
        s1Sum <= sumAB;
        s1Idx <= strobes.issueIdx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.loadEn) begin
      for (int l = 0; l < WPB; l++) begin
        mem[ADDR_W'(int'(strobes.loadBeat) * WPB + l)] <= loadData[l*WORD_W +: WORD_W];
      end
    end else if (strobes.retireEn) begin
      mem[s1Idx[ADDR_W-1:0]] <= wbVal;
    end
  end

  for (genvar g = 0; g < WPB; g++) begin : gRdLane
    assign rdData[g*WORD_W +: WORD_W] = mem[ADDR_W'(int'(strobes.rdWord) * WPB + g)];
  end

  AST_LOAD_EXCL_PASS: assert property (@(posedge clk) disable iff (rst)
    strobes.loadEn |-> (!strobes.issueEn && !strobes.retireEn)); // R3
  AST_PASS_ORDER: assert property (@(posedge clk) disable iff (rst)
    (strobes.issueEn && strobes.retireEn) |-> strobes.issueIdx == s1Idx + 1'b1); // R4
  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (rst)
    strobes.clearAcc |=> acc == '0); // R4
endmodule

// File: rtl/seedHashRng.sv
module seedHashRng
  import rngPkg::*;
#(
  parameter int STAGE_CYCLES = 5,
  parameter int ROT_AMT      = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              genReq,
  input  logic              readReq,
  inout  wire  [DATA_W-1:0] dataIo,
  output logic              ready,
  output logic              done
);
  ctrlStrobes_t      strobes;
  logic [DATA_W-1:0] rdData;
  logic [DATA_W-1:0] loadData;

  assign loadData = dataIo;
  assign dataIo   = done ? rdData : 'z;

  rngCtrl #(.STAGE_CYCLES(STAGE_CYCLES)) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .genReq (genReq),
    .readReq(readReq),
    .ready  (ready),
    .done   (done),
    .strobes(strobes)
  );

  rngDatapath #(.ROT_AMT(ROT_AMT)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .loadData(loadData),
    .rdData  (rdData)
  );
endmodule

// File: tb/seedHashRng_tb_top.sv
module seedHashRng_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        genReq = 1'b0;
  logic        readReq = 1'b0;
  logic        tbOe = 1'b0;
  logic [63:0] tbDrive = '0;
  wire  [63:0] dataIo;
  logic        ready;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] mdl [32];

  assign dataIo = tbOe ? tbDrive : 'z;

  seedHashRng dut_i (
    .clk(clk), .rst(rst), .genReq(genReq), .readReq(readReq),
    .dataIo(dataIo), .ready(ready), .done(done)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL R5 watchdog actual=%0d expected<100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] beatVal(input int run, input int k);
    return {32'(run * 32'h9E3779B1 + k * 32'h0101_0F3), 32'(k * 32'h2545F491 ^ run * 32'h77)};
  endfunction

  task automatic mdlHash();
    logic [31:0] acc;
    logic [31:0] s;
    acc = '0;
    for (int p = 0; p < 256; p++) begin
      s = mdl[p % 32] + mdl[(p + 1) % 32];
      acc = acc + ((s << 7) | (s >> 25));
      mdl[p % 32] = acc + 32'(p);
    end
  endtask

  // called at a negedge; returns at a negedge
  task automatic resetDut();
    rst = 1'b1; genReq = 1'b0; readReq = 1'b0; tbOe = 1'b0;
    repeat (3) @(negedge clk);
    check(ready == 1'b1 && done == 1'b0, "R1 reset state", {62'd0, ready, done}, 64'd2);
    rst = 1'b0;
  endtask

  // drives nBeats seed beats starting at beat pointer 0
  task automatic loadSeed(input int run, input int nBeats, input bit readDuring);
    for (int k = 0; k < nBeats; k++) begin
      tbOe = 1'b1;
      tbDrive = beatVal(run, k);
      readReq = readDuring && (k == 3);
      mdl[2 * (k % 16)]     = tbDrive[31:0];
      mdl[2 * (k % 16) + 1] = tbDrive[63:32];
      @(negedge clk);
    end
    readReq = 1'b0;
  endtask

  task automatic startGen(input logic [63:0] junk);
    tbDrive = junk;
    genReq = 1'b1;
    @(negedge clk);
    genReq = 1'b0;
    tbOe = 1'b0;
    check(ready == 1'b0 && done == 1'b0, "R3 ready drops after start", {62'd0, ready, done}, 64'd0);
  endtask

  task automatic waitDone(input int genAt, input int readAt);
    int n;
    n = 0;
    while (!done && n < 5000) begin
      genReq = (n == genAt);
      readReq = (n == readAt);
      @(negedge clk);
      n++;
    end
    genReq = 1'b0; readReq = 1'b0;
    check(n == 1285, "R5 run length", 64'(n), 64'd1285);
  endtask

  task automatic readOut(input string tag);
    for (int r = 0; r < 4; r++) begin
      check(done == 1'b1, "R6 done held", {63'd0, done}, 64'd1);
      check(dataIo == {mdl[2 * r + 1], mdl[2 * r]}, tag, dataIo, {mdl[2 * r + 1], mdl[2 * r]});
      readReq = 1'b1;
      @(negedge clk);
      readReq = 1'b0;
    end
    check(ready == 1'b1 && done == 1'b0, "R7 release after last read", {62'd0, ready, done}, 64'd2);
  endtask

  task automatic testBasic();
    loadSeed(1, 16, 1'b0);
    startGen(64'hDEAD_BEEF_0000_0001);
    mdlHash();
    waitDone(-1, -1);
    readOut("R4 R6 basic result");
  endtask

  task automatic testGenWithBeat();
    loadSeed(2, 15, 1'b0);
    startGen(64'hFFFF_0000_FFFF_0000);
    mdlHash();
    waitDone(-1, -1);
    readOut("R3 start cycle not stored");
  endtask

  task automatic testWrap();
    loadSeed(3, 20, 1'b1);
    startGen(64'h1234_5678_9ABC_DEF0);
    mdlHash();
    waitDone(-1, -1);
    readOut("R2 beat wrap and R9 read while loading");
  endtask

  task automatic testIgnored();
    loadSeed(4, 16, 1'b0);
    startGen(64'h0);
    mdlHash();
    waitDone(300, 640);
    genReq = 1'b1;
    @(negedge clk);
    genReq = 1'b0;
    check(done == 1'b1 && ready == 1'b0, "R8 start ignored while done", {62'd0, ready, done}, 64'd1);
    readOut("R8 R9 result after ignored requests");
  endtask

  task automatic testMidReset();
    loadSeed(5, 16, 1'b0);
    startGen(64'h0);
    repeat (100) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(ready == 1'b1 && done == 1'b0, "R10 abandon on reset", {62'd0, ready, done}, 64'd2);
    loadSeed(6, 16, 1'b0);
    startGen(64'h0);
    mdlHash();
    waitDone(-1, -1);
    readOut("R10 run after abandoned run");
  endtask

  initial begin
    @(negedge clk);
    resetDut();
    testBasic();
    testGenWithBeat();
    testWrap();
    testIgnored();
    testMidReset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule